// File: doc/BRIEF.md
# I2C Multi-Master Byte Engine

This block is the master side of a two-wire serial bus that other masters may share. A controller gives it one command at a time: begin a transfer (START, or a repeated START when it already holds the bus), send an address byte, send a data byte, receive a data byte, or end the transfer (STOP). The engine drives both bus lines as open-drain outputs. An `_oe` output high means the line is pulled low. The engine also watches both lines. From them it tracks whether the bus is busy, checks the acknowledge that follows every byte it sends, and resolves arbitration against competing masters.

A free-running tick divider sets the bus timing. Each bit takes four tick-long steps. In the first step the engine places data with the clock low. In the second it releases the clock. In the third it samples with the clock high. In the fourth it pulls the clock low again. While sending, the engine compares each released '1' against the line, in address bytes and data bytes alike. If it reads a '0', it drops both lines and gives up ownership. When receiving, it acknowledges each byte unless the command marks that byte as the last. If the address byte gets no acknowledge, the engine ends the transfer by itself.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both line drivers are released, `busy`, `done`, `nack_addr`, `nack_data` and `arb_lost` are 0, and `cmd_ready` is 1.
- R2: `busy` goes to 1 after SDA falls while SCL is high (START) and returns to 0 after SDA rises while SCL is high (STOP), whichever master made the condition.
- R3: Command codes are 1 START, 2 ADDR, 3 WRITE, 4 READ and 5 STOP, and a command is taken when `cmd_valid` and `cmd_ready` are both high. A START given while the engine does not own the bus and `busy` is 1 waits without driving SDA until `busy` clears, then produces a START. A START given while the engine owns the bus produces a repeated START with no STOP before it.
- R4: ADDR and WRITE send `tx_byte` most significant bit first. SDA changes only while SCL is low, and the acknowledge is read during the ninth SCL high phase.
- R5: If the address byte is not acknowledged (SDA high in the ninth clock), `nack_addr` is set and the engine makes a STOP on its own, leaving both lines released and `busy` at 0.
- R6: If a WRITE byte is not acknowledged, `nack_data` is set and the engine keeps the bus, holding SCL low with no STOP.
- R7: READ shifts eight bits in, most significant first, and presents them on `rx_byte`. In the ninth clock the engine pulls SDA low when `cmd_last` is 0 and leaves SDA high when `cmd_last` is 1.
- R8: While sending, if the engine has released SDA for a '1' and samples SDA low with SCL high, it sets `arb_lost`, releases SDA and SCL at once and gives up the bus. This applies to address bytes and data bytes alike.
- R9: ADDR, WRITE, READ or STOP given while the engine does not own the bus completes at once with `done` and `arb_lost` set, and no SCL pulse appears.
- R10: `done`, `nack_addr`, `nack_data` and `arb_lost` keep their value until the next command is taken, and all four read 0 in the cycle after that.
- R11: STOP raises SDA while SCL is high, after which the engine releases both lines and sets `done`.
- R12: Each SCL high phase lasts 2×(`clk_div`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Clock cycles per tick, minus one |
| cmd_valid | input | 1 | Command present |
| cmd | input | 3 | Command code |
| cmd_last | input | 1 | For READ: no acknowledge on this byte |
| tx_byte | input | 8 | Byte to send for ADDR or WRITE |
| cmd_ready | output | 1 | Engine idle, able to take a command |
| rx_byte | output | 8 | Last byte received |
| busy | output | 1 | Bus busy, from observed START and STOP |
| done | output | 1 | Last command finished |
| nack_addr | output | 1 | Address byte not acknowledged |
| nack_data | output | 1 | Data byte not acknowledged |
| arb_lost | output | 1 | Arbitration lost, or the command needed bus ownership |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Two functions can fall in the same cycle: a START waiting for the bus, and the bus turning idle because another master made a STOP. Both depend on the same `busy` edge. The bench provokes this by letting a competing master win arbitration in a data byte, then issuing START while that master still holds SDA low. It then releases SDA to form the STOP. The bench judges the result in two ways. First, during the wait SDA must stay undriven, `cmd_ready` must stay low and no START may appear. Second, exactly one new START must follow the STOP, with `busy` set again afterwards.

// File: rtl/i2c_arb_master.sv
module i2c_arb_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd,
  input  logic             cmd_last,
  input  logic [7:0]       tx_byte,
  output logic             cmd_ready,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             done,
  output logic             nack_addr,
  output logic             nack_data,
  output logic             arb_lost,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_ADDR  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;
  localparam logic [2:0] OP_STOP  = 3'd5;
  localparam int         BITS     = 8;
  localparam logic [3:0] ACK_SLOT = 4'(BITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_SHIFT, S_STOP} state_t;

  state_t           st;
  logic [1:0]       ph;
  logic [3:0]       bcnt;
  logic [7:0]       sh;
  logic             rd, is_addr, last, own;
  logic [DIV_W-1:0] cnt;
  logic             sda_q, scl_q;
  logic             tick, start_det, stop_det;

  assign tick      = (cnt == '0);
  assign cmd_ready = (st == S_IDLE);
  assign start_det = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_det  = scl_q & scl_i & ~sda_q & sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sda_q <= 1'b1;
      scl_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
      if (st == S_IDLE || tick) cnt <= clk_div;
      else                      cnt <= cnt - 1'b1;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 2'd0;
      bcnt      <= 4'd0;
      sh        <= 8'd0;
      rx_byte   <= 8'd0;
      rd        <= 1'b0;
      is_addr   <= 1'b0;
      last      <= 1'b0;
      own       <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      done      <= 1'b0;
      nack_addr <= 1'b0;
      nack_data <= 1'b0;
      arb_lost  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          done      <= 1'b0;
          nack_addr <= 1'b0;
          nack_data <= 1'b0;
          arb_lost  <= 1'b0;
          ph        <= 2'd0;
          bcnt      <= 4'd0;
          case (cmd)
            OP_START: st <= S_START;
            OP_ADDR, OP_WRITE, OP_READ: begin
              if (own) begin
                st      <= S_SHIFT;
                sh      <= tx_byte;
                rd      <= (cmd == OP_READ);
                is_addr <= (cmd == OP_ADDR);
                last    <= cmd_last;
              end else begin
                done     <= 1'b1;
                arb_lost <= 1'b1;
              end
            end
            OP_STOP: begin
              if (own) st <= S_STOP;
              else begin
                done     <= 1'b1;
                arb_lost <= 1'b1;
              end
            end
            default: done <= 1'b1;
          endcase
        end

        S_START: if (tick) begin
          if (!own && busy) ph <= 2'd0;
          else begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: begin sda_oe <= 1'b1; own <= 1'b1; end
              default: begin scl_oe <= 1'b1; done <= 1'b1; st <= S_IDLE; end
            endcase
          end
        end

        S_SHIFT: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: begin
              if (bcnt < ACK_SLOT) sda_oe <= rd ? 1'b0 : ~sh[7];
              else                 sda_oe <= rd ? ~last : 1'b0;
            end
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (bcnt < ACK_SLOT) begin
                if (rd) sh <= {sh[6:0], sda_i};
                else if (!sda_oe && !sda_i) begin
                  scl_oe   <= 1'b0;
                  own      <= 1'b0;
                  arb_lost <= 1'b1;
                  done     <= 1'b1;
                  st       <= S_IDLE;
                end else sh <= {sh[6:0], 1'b0};
              end else if (!rd && sda_i) begin
                if (is_addr) nack_addr <= 1'b1;
                else         nack_data <= 1'b1;
              end
            end
            default: begin
              scl_oe <= 1'b1;
              bcnt   <= bcnt + 4'd1;
              if (bcnt == ACK_SLOT) begin
                if (rd) rx_byte <= sh;
                if (nack_addr) st <= S_STOP;
                else begin
                  done <= 1'b1;
                  st   <= S_IDLE;
                end
              end
            end
          endcase
        end

        default: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin own <= 1'b0; done <= 1'b1; st <= S_IDLE; end
          endcase
        end
      endcase
    end
  end

  // R4
  sda_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && $past(st == S_SHIFT) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  // R3
  start_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && !own && busy) |-> !sda_oe);

  // R8
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!sda_oe && !scl_oe && !own));

  // R5
  addr_nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && nack_addr) |-> (!own && !scl_oe && !sda_oe));

  // R7
  last_byte_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && rd && last && bcnt == ACK_SLOT) |-> !sda_oe);

  // R10
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && cmd == OP_START) |=> (!done && !nack_addr && !nack_data && !arb_lost));

endmodule

// File: tb/i2c_arb_master_bench.sv
module i2c_arb_master_bench;
  localparam int DIV = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] clk_div = 8'(DIV);
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic       cmd_last = 1'b0;
  logic [7:0] tx_byte = 8'd0;
  logic       cmd_ready, busy, done, nack_addr, nack_data, arb_lost;
  logic [7:0] rx_byte;
  logic       scl_oe, sda_oe, scl_i, sda_i;
  logic       slv_low = 1'b0, oth_low = 1'b0;

  assign scl_i = ~scl_oe;
  assign sda_i = ~(sda_oe | slv_low | oth_low);

  i2c_arb_master #(.DIV_W(8)) u_i2c_arb_master (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_last(cmd_last), .tx_byte(tx_byte),
    .cmd_ready(cmd_ready), .rx_byte(rx_byte), .busy(busy), .done(done),
    .nack_addr(nack_addr), .nack_data(nack_data), .arb_lost(arb_lost),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0;
  int start_cnt = 0, stop_cnt = 0, nbits = 0, hi_cycles = 0;
  logic [8:0] cap = 9'd0;
  time t_rise = 0;

  always @(negedge sda_i) if (scl_i === 1'b1) start_cnt++;
  always @(posedge sda_i) if (scl_i === 1'b1) stop_cnt++;
  always @(posedge scl_i) begin cap = {cap[7:0], sda_i}; nbits++; t_rise = $time; end
  always @(negedge scl_i) hi_cycles = int'(($time - t_rise) / 10);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [7:0] b, input logic l);
    @(negedge clk);
    cap = 9'd0; nbits = 0;
    cmd = c; tx_byte = b; cmd_last = l; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done;
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk("R4 command completes", done, 1);
  endtask

  task automatic slave_ack(input logic ack);
    repeat (8) @(negedge scl_i);
    slv_low = ack;
    @(negedge scl_i);
    slv_low = 1'b0;
  endtask

  task automatic slave_send(input logic [7:0] b);
    slv_low = ~b[7];
    for (int i = 6; i >= 0; i--) begin @(negedge scl_i); slv_low = ~b[i]; end
    @(negedge scl_i);
    slv_low = 1'b0;
  endtask

  task automatic other_send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      oth_low = ~b[i];
      if (i > 0) begin
        @(negedge scl_i or posedge arb_lost);
        if (arb_lost) break;
      end
    end
    if (!arb_lost) begin @(negedge scl_i); oth_low = 1'b0; end
  endtask

  task automatic do_stop;
    int p = stop_cnt;
    issue(3'd5, 8'd0, 1'b0);
    wait_done;
    chk("R11 stop seen", stop_cnt - p, 1);
    chk("R2 busy cleared", busy, 0);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic test_reset;
    chk("R1 scl/sda released", {scl_oe, sda_oe}, 0);
    chk("R1 flags", {busy, done, nack_addr, nack_data, arb_lost}, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic test_write;
    int s0 = start_cnt;
    int p0 = stop_cnt;
    issue(3'd1, 8'd0, 1'b0);
    wait_done;
    chk("R2 busy after start", busy, 1);
    chk("R3 one start", start_cnt - s0, 1);
    fork
      begin issue(3'd2, 8'h5A, 1'b0); wait_done; end
      slave_ack(1'b1);
    join
    chk("R4 address bits and ack", cap, 9'h0B4);
    chk("R4 nine clocks", nbits, 9);
    chk("R5 no nack_addr", nack_addr, 0);
    chk("R12 scl high width", hi_cycles, 2 * (DIV + 1));
    fork
      begin issue(3'd3, 8'hC3, 1'b0); wait_done; end
      slave_ack(1'b0);
    join
    chk("R4 data bits", cap, 9'h187);
    chk("R6 nack_data", nack_data, 1);
    chk("R6 nack_addr clear", nack_addr, 0);
    chk("R6 scl held", scl_oe, 1);
    chk("R6 no stop", stop_cnt - p0, 0);
    issue(3'd5, 8'd0, 1'b0);
    chk("R10 nack_data cleared", nack_data, 0);
    wait_done;
    chk("R2 busy cleared", busy, 0);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic test_read;
    int s0, p0;
    issue(3'd1, 8'd0, 1'b0);
    wait_done;
    fork
      begin issue(3'd2, 8'hA1, 1'b0); wait_done; end
      slave_ack(1'b1);
    join
    fork
      begin issue(3'd4, 8'd0, 1'b0); wait_done; end
      slave_send(8'hA5);
    join
    chk("R7 rx byte", rx_byte, 8'hA5);
    chk("R7 ack driven", cap, 9'h14A);
    fork
      begin issue(3'd4, 8'd0, 1'b1); wait_done; end
      slave_send(8'h3C);
    join
    chk("R7 rx last byte", rx_byte, 8'h3C);
    chk("R7 nack on last", cap[0], 1);
    s0 = start_cnt; p0 = stop_cnt;
    issue(3'd1, 8'd0, 1'b0);
    wait_done;
    chk("R3 repeated start", start_cnt - s0, 1);
    chk("R3 no stop before restart", stop_cnt - p0, 0);
    chk("R2 busy kept", busy, 1);
    fork
      begin issue(3'd2, 8'h90, 1'b0); wait_done; end
      slave_ack(1'b0);
    join
    chk("R5 nack_addr", nack_addr, 1);
    chk("R5 auto stop", stop_cnt - p0, 1);
    chk("R5 bus idle", busy, 0);
    chk("R5 lines released", {scl_oe, sda_oe}, 0);
    issue(3'd1, 8'd0, 1'b0);
    chk("R10 nack_addr cleared", nack_addr, 0);
    chk("R10 done cleared", done, 0);
    wait_done;
    do_stop;
  endtask

  task automatic test_arb;
    int s0;
    issue(3'd1, 8'd0, 1'b0);
    wait_done;
    fork
      begin issue(3'd2, 8'h5A, 1'b0); wait_done; end
      slave_ack(1'b1);
      other_send(8'h5A);
    join
    chk("R8 tie in address", arb_lost, 0);
    chk("R8 address acked", cap, 9'h0B4);
    fork
      begin issue(3'd3, 8'hF0, 1'b0); wait_done; end
      other_send(8'hE0);
    join
    chk("R8 lost in data", arb_lost, 1);
    chk("R8 stopped at bit", nbits, 4);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    chk("R2 bus still busy", busy, 1);
    issue(3'd3, 8'h55, 1'b0);
    chk("R9 done at once", done, 1);
    chk("R9 arb_lost", arb_lost, 1);
    repeat (20) @(negedge clk);
    chk("R9 no clock", nbits, 0);
    s0 = start_cnt;
    issue(3'd1, 8'd0, 1'b0);
    repeat (40) @(negedge clk);
    chk("R3 held off ready", cmd_ready, 0);
    chk("R3 held off sda", sda_oe, 0);
    chk("R3 no start while busy", start_cnt - s0, 0);
    oth_low = 1'b0;
    wait_done;
    chk("R3 start after idle", start_cnt - s0, 1);
    chk("R2 busy again", busy, 1);
    do_stop;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    start_cnt = 0; stop_cnt = 0;
    test_reset;
    test_write;
    test_read;
    test_arb;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule